// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

A 32-bit stack machine that runs a byte-wide instruction stream out of a word-organised memory held inside the block. Operands live on a stack in that same memory. The only architectural state outside the memory is a program counter, a stack pointer and a flag that marks an immediate chain in progress. The instruction set has chained 7-bit immediates, stack-pointer-relative and absolute loads and stores, binary and unary operations, bit reversal, control transfer through a popped address, a trap that sends unimplemented opcodes to fixed 32-byte slots, and a breakpoint that halts the core.

A host fills the memory while `run` is low, which also holds the core in its start state. It then raises `run` and waits for `halted`. After the breakpoint it reads the memory back through the same port. An edge-sensed interrupt request pushes the current program counter and sends execution to address 0x20. A one-cycle acknowledge pulse marks the moment the interrupt is taken.

Top module: `stackm_core`

## Requirements
- R1: While `rst` is high or `run` is low, the core sits at PC 0 with SP = 4*(MEM_WORDS-1), the immediate flag clear, `halted` low and no acknowledge.
- R2: Instruction bytes are fetched big-endian: byte address a is word a/4, bits [31-8*(a%4) -: 8]. A push first lowers SP by 4 and then writes the word at SP. An immediate opcode 1xxxxxxx with the flag clear pushes the 7-bit field sign-extended and sets the flag.
- R3: An immediate opcode with the flag already set replaces the top of stack with (top << 7) | field and leaves SP unchanged.
- R4: ADD 0x05, AND 0x06 and OR 0x07 pop two words and push the result. NOT 0x09 inverts the top word. FLIP 0x0A reverses its bit order. NOP 0x0B changes only the PC.
- R5: 011fffff pushes the word at SP+f*4. 0001ffff adds the word at SP+f*4 into the top word. 010fffff pops the top word and writes it at (SP before the pop)+f*4.
- R6: LOAD 0x08 replaces the top word, taken as an address, with the word stored there. STORE 0x0C pops an address and then a value and writes the value. Both ignore address bits 1:0.
- R7: PUSHSP 0x02 pushes the SP value it had before the push. POPSP 0x0D loads SP with the popped top word.
- R8: 001fffff pushes the address of the following byte and jumps to f*32. POPPC 0x04 pops a word into the PC.
- R9: BREAKPOINT 0x00 raises `halted`, holds the PC at the breakpoint's own address and hands the memory port to the host until `run` falls.
- R10: A rising edge on `irq_req` is taken before the next fetch: the current PC is pushed, the PC becomes 0x20 and `irq_ack` pulses for one cycle. A request held high is taken only once.
- R11: Every instruction except the immediate opcode clears the flag. While the flag is set, a pending interrupt waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High lets the core execute. Low holds it at start and gives the memory to the host |
| irq_req | input | 1 | Interrupt request, sensed on its rising edge |
| host_we | input | 1 | Host write strobe, used while the host owns memory |
| host_addr | input | AW | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Word read at host_addr, one cycle after the address |
| irq_ack | output | 1 | One-cycle pulse when the interrupt is taken |
| halted | output | 1 | Breakpoint reached |
| pc_o | output | DATA_W | Program counter (byte address) |
| sp_o | output | DATA_W | Stack pointer (byte address) |
| imm_flag | output | 1 | Immediate-chain flag |

## Verification
The hardest case to reach from the ports is an interrupt that arrives while an immediate chain keeps the flag set. It must wait, and it must be taken as soon as the first non-immediate instruction has cleared the flag. The stimulus runs a program of thirty-one back-to-back immediate opcodes followed by one NOP. The request is raised a few cycles in, once the flag is set, and held high. The return address left on the stack must then be exactly the byte after that NOP, and exactly one acknowledge must appear.

// File: rtl/stackm_pkg.sv
package stackm_pkg;

  typedef enum logic [4:0] {
    OP_NOP, OP_BRK, OP_IM, OP_STORESP, OP_LOADSP, OP_ADDSP, OP_EMU,
    OP_POPPC, OP_LOAD, OP_STORE, OP_PUSHSP, OP_POPSP,
    OP_ADD, OP_AND, OP_OR, OP_NOT, OP_FLIP
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_RD2, ST_LDX, ST_WB, ST_HALT
  } st_e;

  typedef enum logic [2:0] {
    FN_PASS, FN_CHAIN, FN_ADD, FN_AND, FN_OR, FN_NOT, FN_FLIP
  } fn_e;

endpackage

// File: rtl/stackm_ram.sv
module stackm_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-before-write, registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/stackm_decode.sv
module stackm_decode
  import stackm_pkg::*;
(
  input  logic [7:0] opc,
  output op_e        op,
  output logic [6:0] imm7,
  output logic [6:0] sp_off,
  output logic [9:0] trap_addr
);

  always_comb begin
    casez (opc)
      8'b1???????: op = OP_IM;
      8'b010?????: op = OP_STORESP;
      8'b011?????: op = OP_LOADSP;
      8'b001?????: op = OP_EMU;
      8'b0001????: op = OP_ADDSP;
      8'h00:       op = OP_BRK;
      8'h02:       op = OP_PUSHSP;
      8'h04:       op = OP_POPPC;
      8'h05:       op = OP_ADD;
      8'h06:       op = OP_AND;
      8'h07:       op = OP_OR;
      8'h08:       op = OP_LOAD;
      8'h09:       op = OP_NOT;
      8'h0A:       op = OP_FLIP;
      8'h0C:       op = OP_STORE;
      8'h0D:       op = OP_POPSP;
      default:     op = OP_NOP;
    endcase
  end

  assign imm7      = opc[6:0];
  // byte offset from SP: four-bit field for the add form, five-bit otherwise
  assign sp_off    = (op == OP_ADDSP) ? {1'b0, opc[3:0], 2'b00} : {opc[4:0], 2'b00};
  assign trap_addr = {opc[4:0], 5'b00000};

endmodule

// File: rtl/stackm_alu.sv
module stackm_alu
  import stackm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fn_e               fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [6:0]        imm7,
  output logic [DATA_W-1:0] y
);

  logic [DATA_W-1:0] rev;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = b[DATA_W-1-i];
  end

  always_comb begin
    case (fn)
      FN_CHAIN: y = {b[DATA_W-8:0], imm7};
      FN_ADD:   y = a + b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_NOT:   y = ~b;
      FN_FLIP:  y = rev;
      default:  y = b;
    endcase
  end

endmodule

// File: rtl/stackm_core.sv
module stackm_core
  import stackm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 256,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              irq_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_ack,
  output logic              halted,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              imm_flag
);

  localparam logic [DATA_W-1:0] SP_TOP  = DATA_W'((MEM_WORDS - 1) * 4);
  localparam logic [DATA_W-1:0] IRQ_VEC = DATA_W'(32'h20);
  localparam logic [DATA_W-1:0] STEP    = DATA_W'(4);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  function automatic logic [AW-1:0] widx(input logic [DATA_W-1:0] b);
    return b[AW+1:2];
  endfunction

  // architectural and sequencing state
  st_e               st_q, st_n;
  op_e               op_q, op_n;
  logic [DATA_W-1:0] pc_q, pc_n, sp_q, sp_n, a_q, a_n;
  logic [6:0]        off_q, off_n, imm_q, imm_n;
  logic              idim_q, idim_n, halted_q, halt_n, ack_q, ack_n;
  logic              irq_q, pend_q, take;

  // memory port
  logic              m_we, c_we, host_sel;
  logic [AW-1:0]     m_addr, c_addr;
  logic [DATA_W-1:0] m_wdata, c_wdata, m_rdata;

  // decode and ALU
  logic [7:0]        opc;
  op_e               dec_op;
  logic [6:0]        dec_imm, dec_off;
  logic [9:0]        dec_trap;
  fn_e               fn;
  logic [DATA_W-1:0] alu_y, sext, off_w, dec_off_w;

  assign host_sel = !run || halted_q;
  assign m_we     = host_sel ? host_we    : c_we;
  assign m_addr   = host_sel ? host_addr  : c_addr;
  assign m_wdata  = host_sel ? host_wdata : c_wdata;

  stackm_ram #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS)) u_ram (
    .clk   (clk),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_wdata),
    .rdata (m_rdata)
  );

  // big-endian byte pick within the fetched word
  assign opc = m_rdata[(5'd24 - {pc_q[1:0], 3'b000}) +: 8];

  stackm_decode u_dec (
    .opc       (opc),
    .op        (dec_op),
    .imm7      (dec_imm),
    .sp_off    (dec_off),
    .trap_addr (dec_trap)
  );

  always_comb begin
    case (op_q)
      OP_IM:            fn = FN_CHAIN;
      OP_ADD, OP_ADDSP: fn = FN_ADD;
      OP_AND:           fn = FN_AND;
      OP_OR:            fn = FN_OR;
      OP_NOT:           fn = FN_NOT;
      OP_FLIP:          fn = FN_FLIP;
      default:          fn = FN_PASS;
    endcase
  end

  stackm_alu #(.DATA_W(DATA_W)) u_alu (
    .fn   (fn),
    .a    (a_q),
    .b    (m_rdata),
    .imm7 (imm_q),
    .y    (alu_y)
  );

  assign sext      = {{(DATA_W-7){dec_imm[6]}}, dec_imm};
  assign dec_off_w = {{(DATA_W-7){1'b0}}, dec_off};
  assign off_w     = {{(DATA_W-7){1'b0}}, off_q};

  always_comb begin
    st_n    = st_q;
    op_n    = op_q;
    pc_n    = pc_q;
    sp_n    = sp_q;
    a_n     = a_q;
    off_n   = off_q;
    imm_n   = imm_q;
    idim_n  = idim_q;
    halt_n  = halted_q;
    ack_n   = 1'b0;
    take    = 1'b0;
    c_we    = 1'b0;
    c_addr  = widx(sp_q);
    c_wdata = alu_y;
    case (st_q)
      ST_FETCH: begin
        if (pend_q && !idim_q) begin
          c_we    = 1'b1;
          c_addr  = widx(sp_q - STEP);
          c_wdata = pc_q;
          sp_n    = sp_q - STEP;
          pc_n    = IRQ_VEC;
          ack_n   = 1'b1;
          take    = 1'b1;
        end else begin
          c_addr = widx(pc_q);
          st_n   = ST_DEC;
        end
      end
      ST_DEC: begin
        op_n   = dec_op;
        off_n  = dec_off;
        imm_n  = dec_imm;
        idim_n = (dec_op == OP_IM);
        pc_n   = pc_q + ONE;
        st_n   = ST_FETCH;
        case (dec_op)
          OP_IM: begin
            if (!idim_q) begin
              c_we    = 1'b1;
              c_addr  = widx(sp_q - STEP);
              c_wdata = sext;
              sp_n    = sp_q - STEP;
            end else begin
              st_n = ST_WB;
            end
          end
          OP_STORESP, OP_POPPC, OP_POPSP, OP_NOT, OP_FLIP: st_n = ST_WB;
          OP_LOAD:                                         st_n = ST_LDX;
          OP_STORE, OP_ADD, OP_AND, OP_OR:                 st_n = ST_RD2;
          OP_LOADSP: begin
            c_addr = widx(sp_q + dec_off_w);
            st_n   = ST_WB;
          end
          OP_ADDSP: begin
            c_addr = widx(sp_q + dec_off_w);
            st_n   = ST_RD2;
          end
          OP_EMU: begin
            c_we    = 1'b1;
            c_addr  = widx(sp_q - STEP);
            c_wdata = pc_q + ONE;
            sp_n    = sp_q - STEP;
            pc_n    = {{(DATA_W-10){1'b0}}, dec_trap};
          end
          OP_PUSHSP: begin
            c_we    = 1'b1;
            c_addr  = widx(sp_q - STEP);
            c_wdata = sp_q;
            sp_n    = sp_q - STEP;
          end
          OP_BRK: begin
            pc_n   = pc_q;
            halt_n = 1'b1;
            st_n   = ST_HALT;
          end
          default: ;
        endcase
      end
      ST_RD2: begin
        a_n    = m_rdata;
        c_addr = (op_q == OP_ADDSP) ? widx(sp_q) : widx(sp_q + STEP);
        st_n   = ST_WB;
      end
      ST_LDX: begin
        c_addr = widx(m_rdata);
        st_n   = ST_WB;
      end
      ST_WB: begin
        st_n = ST_FETCH;
        case (op_q)
          OP_IM, OP_NOT, OP_FLIP, OP_LOAD, OP_ADDSP: c_we = 1'b1;
          OP_STORESP: begin
            c_we   = 1'b1;
            c_addr = widx(sp_q + off_w);
            sp_n   = sp_q + STEP;
          end
          OP_LOADSP: begin
            c_we   = 1'b1;
            c_addr = widx(sp_q - STEP);
            sp_n   = sp_q - STEP;
          end
          OP_POPPC: begin
            pc_n = m_rdata;
            sp_n = sp_q + STEP;
          end
          OP_POPSP: sp_n = m_rdata;
          OP_STORE: begin
            c_we    = 1'b1;
            c_addr  = widx(a_q);
            c_wdata = m_rdata;
            sp_n    = sp_q + STEP + STEP;
          end
          OP_ADD, OP_AND, OP_OR: begin
            c_we   = 1'b1;
            c_addr = widx(sp_q + STEP);
            sp_n   = sp_q + STEP;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_req;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      st_q     <= ST_FETCH;
      op_q     <= OP_NOP;
      pc_q     <= '0;
      sp_q     <= SP_TOP;
      a_q      <= '0;
      off_q    <= '0;
      imm_q    <= '0;
      idim_q   <= 1'b0;
      halted_q <= 1'b0;
      ack_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      op_q     <= op_n;
      pc_q     <= pc_n;
      sp_q     <= sp_n;
      a_q      <= a_n;
      off_q    <= off_n;
      imm_q    <= imm_n;
      idim_q   <= idim_n;
      halted_q <= halt_n;
      ack_q    <= ack_n;
      if (take)                   pend_q <= 1'b0;
      else if (irq_req && !irq_q) pend_q <= 1'b1;
    end
  end

  assign host_rdata = m_rdata;
  assign irq_ack    = ack_q;
  assign halted     = halted_q;
  assign pc_o       = pc_q;
  assign sp_o       = sp_q;
  assign imm_flag   = idim_q;

  // ---------------- assertions ----------------
  assert_idle_state_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pc_q == '0 && sp_q == SP_TOP && !idim_q && !halted_q));

  assert_first_push_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(idim_q) |-> sp_q == $past(sp_q) - STEP);

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (halted_q && run) |=> halted_q);

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);

  assert_ack_vector_R10: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> pc_q == IRQ_VEC);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> !$past(idim_q));

endmodule

// File: tb/stackm_core_bench.sv
module stackm_core_bench;

  localparam int WORDS  = 256;
  localparam int AW     = $clog2(WORDS);
  localparam int SP_TOP = (WORDS - 1) * 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        irq_req = 1'b0;
  logic        host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, pc_o, sp_o;
  logic        irq_ack, halted, imm_flag;

  int checks = 0;
  int errors = 0;
  int ack_cnt = 0;
  bit finished = 0;
  logic [7:0] img [0:4*WORDS-1];

  always #10 clk = ~clk;

  always @(posedge clk) if (irq_ack) ack_cnt <= ack_cnt + 1;

  stackm_core #(.DATA_W(32), .MEM_WORDS(WORDS)) u_stackm_core (
    .clk(clk), .rst(rst), .run(run), .irq_req(irq_req),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_ack(irq_ack), .halted(halted),
    .pc_o(pc_o), .sp_o(sp_o), .imm_flag(imm_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic prep();
    @(negedge clk);
    run = 1'b0;
    irq_req = 1'b0;
    for (int i = 0; i < 4*WORDS; i++) img[i] = 8'h00;
  endtask

  task automatic load_img();
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      host_we    = 1'b1;
      host_addr  = AW'(w);
      host_wdata = {img[4*w], img[4*w+1], img[4*w+2], img[4*w+3]};
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // irq_at < 0: no interrupt; otherwise raise it that many cycles after start and hold
  task automatic go(input int irq_at, output bit ok);
    load_img();
    @(negedge clk);
    run = 1'b1;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i == irq_at) irq_req = 1'b1;
      if (halted) begin ok = 1; break; end
    end
    irq_req = 1'b0;
    chk("R9 halt reached", {31'b0, ok}, 32'd1);
  endtask

  task automatic rd(input int byte_addr, output logic [31:0] v);
    @(negedge clk);
    host_addr = AW'(byte_addr / 4);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 sp", sp_o, SP_TOP);
    chk("R1 flag", {31'b0, imm_flag}, 32'd0);
    chk("R1 halted", {31'b0, halted}, 32'd0);
    chk("R1 ack", {31'b0, irq_ack}, 32'd0);
  endtask

  task automatic t_imm();
    bit ok; logic [31:0] v;
    prep(); img[0] = 8'hFF; img[1] = 8'h0B;
    go(-1, ok);
    rd(SP_TOP - 4, v);
    chk("R2 negative sign-extended", v, 32'hFFFF_FFFF);
    chk("R2 sp after push", sp_o, SP_TOP - 4);
    chk("R9 pc at breakpoint", pc_o, 32'd2);
    prep(); img[0] = 8'h81; img[1] = 8'h82;
    go(-1, ok);
    rd(SP_TOP - 4, v);
    chk("R3 chained value", v, 32'd130);
    chk("R3 sp unchanged by chain", sp_o, SP_TOP - 4);
    chk("R11 flag cleared by breakpoint", {31'b0, imm_flag}, 32'd0);
  endtask

  task automatic t_arith();
    bit ok; logic [31:0] v;
    prep(); img[0] = 8'h85; img[1] = 8'h0B; img[2] = 8'h83; img[3] = 8'h05;
    go(-1, ok);
    rd(SP_TOP - 4, v);
    chk("R4 add", v, 32'd8);
    chk("R4 add pops", sp_o, SP_TOP - 4);
    prep();
    img[0] = 8'h8C; img[1] = 8'h0B; img[2] = 8'h8A; img[3] = 8'h06;
    img[4] = 8'h09; img[5] = 8'h0A;
    go(-1, ok);
    rd(SP_TOP - 4, v);
    chk("R4 and/not/flip", v, rev32(~(32'd12 & 32'd10)));
    chk("R4 pc", pc_o, 32'd6);
    prep(); img[0] = 8'h85; img[1] = 8'h0B; img[2] = 8'h83; img[3] = 8'h07;
    go(-1, ok);
    rd(SP_TOP - 4, v);
    chk("R4 or", v, 32'd7);
  endtask

  task automatic t_sprel();
    bit ok; logic [31:0] v;
    prep();
    img[0] = 8'h87; img[1] = 8'h0B; img[2] = 8'h89; img[3] = 8'h61;
    img[4] = 8'h12; img[5] = 8'h41;
    go(-1, ok);
    chk("R5 sp", sp_o, SP_TOP - 8);
    rd(SP_TOP - 8, v);
    chk("R5 loadsp+addsp+storesp", v, 32'd14);
    rd(SP_TOP - 4, v);
    chk("R5 untouched slot", v, 32'd7);
  endtask

  task automatic t_mem();
    bit ok; logic [31:0] v;
    prep();
    img[0] = 8'hAA; img[1] = 8'h0B; img[2] = 8'h84; img[3] = 8'h83;
    img[4] = 8'h0C; img[5] = 8'h84; img[6] = 8'h81; img[7] = 8'h08;
    go(-1, ok);
    rd(32'h200, v);
    chk("R6 store aligned", v, 32'd42);
    rd(SP_TOP - 4, v);
    chk("R6 load aligned", v, 32'd42);
    chk("R6 sp", sp_o, SP_TOP - 4);
  endtask

  task automatic t_spops();
    bit ok; logic [31:0] v;
    prep();
    img[0] = 8'h02; img[1] = 8'h0D; img[2] = 8'h86; img[3] = 8'h80; img[4] = 8'h0D;
    go(-1, ok);
    chk("R7 popsp", sp_o, 32'd768);
    rd(SP_TOP - 4, v);
    chk("R7 slot holds chained value", v, 32'd768);
    prep(); img[0] = 8'h02;
    go(-1, ok);
    rd(SP_TOP - 4, v);
    chk("R7 pushsp value", v, SP_TOP);
  endtask

  task automatic t_flow();
    bit ok; logic [31:0] v;
    prep(); img[0] = 8'h22;
    go(-1, ok);
    chk("R8 emulate target", pc_o, 32'd64);
    rd(SP_TOP - 4, v);
    chk("R8 emulate return address", v, 32'd1);
    prep(); img[0] = 8'h22; img[64] = 8'h04;
    go(-1, ok);
    chk("R8 poppc", pc_o, 32'd1);
    chk("R8 poppc sp", sp_o, SP_TOP);
  endtask

  task automatic t_irq();
    bit ok; int base; logic [31:0] v;
    prep();
    for (int i = 0; i < 32; i++) img[i] = 8'h0B;
    base = ack_cnt;
    go(8, ok);
    chk("R10 vector", pc_o, 32'h20);
    chk("R10 one push", sp_o, SP_TOP - 4);
    chk("R10 single ack on held request", ack_cnt - base, 32'd1);
    rd(SP_TOP - 4, v);
    chk("R10 pushed pc in range", {31'b0, (v >= 1 && v <= 31)}, 32'd1);
  endtask

  task automatic t_mask();
    bit ok; int base; logic [31:0] v;
    prep();
    for (int i = 0; i < 31; i++) img[i] = 8'h81;
    img[31] = 8'h0B;
    base = ack_cnt;
    go(6, ok);
    chk("R11 deferred push sp", sp_o, SP_TOP - 8);
    rd(SP_TOP - 8, v);
    chk("R11 return after nop", v, 32'd32);
    chk("R11 ack count", ack_cnt - base, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_imm();
    t_arith();
    t_sprel();
    t_mem();
    t_spops();
    t_flow();
    t_irq();
    t_mask();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule